// File: doc/BRIEF.md
# Pilot-Inserting Physical Layer Framer

This block sits on the transmit side and assembles physical-layer frames from a stream of already mapped data symbols. A frame is started by a start handshake that also carries the frame length, counted in data slots, and a flag that turns pilot insertion on or off. Both values are captured when the start is accepted. The framer first passes through one slot of header symbols, which an upstream encoder supplies on its own valid/ready stream. It then passes the data slots. When pilots are on, it inserts a fixed block of pilot symbols after every group of sixteen data slots.

Pilot positions follow a grid that counts data slots only. A pilot block that would land directly after the last data slot of the frame, right before the next header, is left out. Every output beat carries a type tag and a last-of-frame marker. A stalled output freezes all sequencing. Data symbols are taken only while a data symbol is being emitted.

Top module: `pl_framer`

## Requirements
- R1: After reset the framer is idle. In that state dout_valid_o=0, dout_type_o=2'b00, start_ready_o=1, hdr_ready_o=0 and din_ready_o=0.
- R2: Every frame begins with SLOT_LEN (90) header beats tagged dout_type_o=2'b01. These carry the header stream's symbols unchanged and in order.
- R3: din_ready_o is high only while the current output beat is a data beat. No data symbol is consumed during header or pilot beats.
- R4: With pilots off, the frame holds exactly n×90 data beats back to back after the header, with no pilot beats.
- R5: With pilots on, every completed group of 16 data slots is followed by 36 pilot beats tagged 2'b11. Each pilot beat has I = Q = round(0.70711 × 2^(SYM_W−1)), which is 1448 for SYM_W=12.
- R6: A pilot block that would directly follow the frame's final data slot is omitted. A frame of n slots therefore carries floor((n−1)/16) pilot blocks.
- R7: dout_last_o is high on the final data beat of the frame and on no other beat.
- R8: While dout_ready_i is low, the framer neither advances nor consumes input. hdr_ready_o and din_ready_o are low, and no symbol is lost or repeated.
- R9: The slot count and pilot flag are captured at start acceptance. Changes to these inputs during a frame have no effect on that frame.
- R10: start_ready_o is low from start acceptance until the frame's final beat has transferred. A start request held during a frame is not taken.
- R11: Data beats, tagged 2'b10, carry the input data symbols unchanged and in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_valid_i | input | 1 | Frame start request |
| start_ready_o | output | 1 | Framer idle, start can be taken |
| pilots_en_i | input | 1 | Pilot insertion on for the requested frame |
| n_slots_i | input | SLOT_CNT_W | Data slots in the requested frame (0 treated as 1) |
| hdr_re_i | input | SYM_W | Header symbol, in-phase |
| hdr_im_i | input | SYM_W | Header symbol, quadrature |
| hdr_valid_i | input | 1 | Header symbol valid |
| hdr_ready_o | output | 1 | Header symbol taken |
| din_re_i | input | SYM_W | Data symbol, in-phase |
| din_im_i | input | SYM_W | Data symbol, quadrature |
| din_valid_i | input | 1 | Data symbol valid |
| din_ready_o | output | 1 | Data symbol taken |
| dout_re_o | output | SYM_W | Output symbol, in-phase |
| dout_im_o | output | SYM_W | Output symbol, quadrature |
| dout_type_o | output | 2 | 00 none, 01 header, 10 data, 11 pilot |
| dout_last_o | output | 1 | Final data beat of the frame |
| dout_valid_o | output | 1 | Output symbol valid |
| dout_ready_i | input | 1 | Downstream accepts the symbol |

## Verification
Several properties are checked on every cycle:
- inputs are taken only on beats of the matching type;
- nothing is consumed under backpressure;
- a pilot beat always carries the fixed pilot value;
- a pilot appears only when pilots are enabled;
- the last marker sits on a data beat;
- the captured configuration does not move during a frame.

Other behaviours need whole frames and are shown only by the bench's scenarios. These are the exact position and count of pilot blocks, the dropping of the final block when the slot count is a multiple of sixteen, the total frame length, and lossless ordering under random stalls.

// File: rtl/pl_framer_pkg.sv
package pl_framer_pkg;

  typedef enum logic [1:0] {
    SEG_IDLE  = 2'd0,
    SEG_HDR   = 2'd1,
    SEG_DATA  = 2'd2,
    SEG_PILOT = 2'd3
  } seg_e;

  localparam logic [1:0] TAG_NONE  = 2'b00;
  localparam logic [1:0] TAG_HDR   = 2'b01;
  localparam logic [1:0] TAG_DATA  = 2'b10;
  localparam logic [1:0] TAG_PILOT = 2'b11;

  // round(2^(w-1) / sqrt(2)) using a 5-digit fixed ratio
  function automatic int pilot_amp(input int w);
    longint full;
    full = longint'(1) << (w - 1);
    return int'((full * 70711 + 50000) / 100000);
  endfunction

endpackage

// File: rtl/pl_frame_seq.sv
module pl_frame_seq
  import pl_framer_pkg::*;
#(
  parameter int SLOT_LEN   = 90,
  parameter int PILOT_LEN  = 36,
  parameter int GRP_SLOTS  = 16,
  parameter int SLOT_CNT_W = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_valid_i,
  output logic                  start_ready_o,
  input  logic                  pilots_en_i,
  input  logic [SLOT_CNT_W-1:0] n_slots_i,
  input  logic                  beat_i,
  output seg_e                  seg_o,
  output logic                  last_o
);

  localparam int SYM_MAX   = (SLOT_LEN > PILOT_LEN) ? SLOT_LEN : PILOT_LEN;
  localparam int SYM_CNT_W = $clog2(SYM_MAX);
  localparam int GRP_W     = (GRP_SLOTS > 1) ? $clog2(GRP_SLOTS) : 1;

  localparam logic [SYM_CNT_W-1:0] SYM_SLOT_END  = SYM_CNT_W'(SLOT_LEN - 1);
  localparam logic [SYM_CNT_W-1:0] SYM_PILOT_END = SYM_CNT_W'(PILOT_LEN - 1);
  localparam logic [GRP_W-1:0]     GRP_END       = GRP_W'(GRP_SLOTS - 1);

  seg_e                  seg_q;
  logic [SYM_CNT_W-1:0]  sym_q;
  logic [GRP_W-1:0]      grp_q;
  logic [SLOT_CNT_W-1:0] slot_q;
  logic [SLOT_CNT_W-1:0] nslots_q;
  logic                  pen_q;

  logic slot_end, frame_end;

  assign slot_end      = (sym_q == SYM_SLOT_END);
  assign frame_end     = slot_end && (slot_q == nslots_q - SLOT_CNT_W'(1));
  assign start_ready_o = (seg_q == SEG_IDLE);
  assign seg_o         = seg_q;
  assign last_o        = (seg_q == SEG_DATA) && frame_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= SEG_IDLE;
      sym_q    <= '0;
      grp_q    <= '0;
      slot_q   <= '0;
      nslots_q <= SLOT_CNT_W'(1);
      pen_q    <= 1'b0;
    end else begin
      unique case (seg_q)
        SEG_IDLE: begin
          if (start_valid_i) begin
            seg_q    <= SEG_HDR;
            sym_q    <= '0;
            grp_q    <= '0;
            slot_q   <= '0;
            nslots_q <= (n_slots_i == '0) ? SLOT_CNT_W'(1) : n_slots_i;
            pen_q    <= pilots_en_i;
          end
        end
        SEG_HDR: begin
          if (beat_i) begin
            if (slot_end) begin
              sym_q <= '0;
              seg_q <= SEG_DATA;
            end else begin
              sym_q <= sym_q + SYM_CNT_W'(1);
            end
          end
        end
        SEG_DATA: begin
          if (beat_i) begin
            if (slot_end) begin
              sym_q <= '0;
              if (frame_end) begin
                seg_q <= SEG_IDLE;
              end else begin
                slot_q <= slot_q + SLOT_CNT_W'(1);
                if (grp_q == GRP_END) begin
                  grp_q <= '0;
                  // a pilot block is only due when the frame continues
                  if (pen_q) seg_q <= SEG_PILOT;
                end else begin
                  grp_q <= grp_q + GRP_W'(1);
                end
              end
            end else begin
              sym_q <= sym_q + SYM_CNT_W'(1);
            end
          end
        end
        SEG_PILOT: begin
          if (beat_i) begin
            if (sym_q == SYM_PILOT_END) begin
              sym_q <= '0;
              seg_q <= SEG_DATA;
            end else begin
              sym_q <= sym_q + SYM_CNT_W'(1);
            end
          end
        end
        default: seg_q <= SEG_IDLE;
      endcase
    end
  end

  p_start_to_hdr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_valid_i && start_ready_o) |=> (seg_q == SEG_HDR));

  p_pilot_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SEG_PILOT) |-> pen_q);

  p_hold_on_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q != SEG_IDLE && !beat_i) |=>
      ($stable(seg_q) && $stable(sym_q) && $stable(slot_q) && $stable(grp_q)));

  p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q != SEG_IDLE) |=>
      (seg_q == SEG_IDLE) || ($stable(nslots_q) && $stable(pen_q)));

endmodule

// File: rtl/pl_sym_mux.sv
module pl_sym_mux
  import pl_framer_pkg::*;
#(
  parameter int SYM_W = 12
) (
  input  seg_e             seg_i,
  input  logic             last_i,
  input  logic [SYM_W-1:0] hdr_re_i,
  input  logic [SYM_W-1:0] hdr_im_i,
  input  logic             hdr_valid_i,
  output logic             hdr_ready_o,
  input  logic [SYM_W-1:0] din_re_i,
  input  logic [SYM_W-1:0] din_im_i,
  input  logic             din_valid_i,
  output logic             din_ready_o,
  output logic [SYM_W-1:0] dout_re_o,
  output logic [SYM_W-1:0] dout_im_o,
  output logic [1:0]       dout_type_o,
  output logic             dout_last_o,
  output logic             dout_valid_o,
  input  logic             dout_ready_i,
  output logic             beat_o
);

  localparam int               PILOT_AMP = pilot_amp(SYM_W);
  localparam logic [SYM_W-1:0] PILOT_SYM = SYM_W'(PILOT_AMP);

  always_comb begin
    dout_re_o    = '0;
    dout_im_o    = '0;
    dout_type_o  = TAG_NONE;
    dout_last_o  = 1'b0;
    dout_valid_o = 1'b0;
    hdr_ready_o  = 1'b0;
    din_ready_o  = 1'b0;
    unique case (seg_i)
      SEG_HDR: begin
        dout_re_o    = hdr_re_i;
        dout_im_o    = hdr_im_i;
        dout_type_o  = TAG_HDR;
        dout_valid_o = hdr_valid_i;
        hdr_ready_o  = dout_ready_i;
      end
      SEG_DATA: begin
        dout_re_o    = din_re_i;
        dout_im_o    = din_im_i;
        dout_type_o  = TAG_DATA;
        dout_last_o  = last_i;
        dout_valid_o = din_valid_i;
        din_ready_o  = dout_ready_i;
      end
      SEG_PILOT: begin
        dout_re_o    = PILOT_SYM;
        dout_im_o    = PILOT_SYM;
        dout_type_o  = TAG_PILOT;
        dout_valid_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign beat_o = dout_valid_o && dout_ready_i;

endmodule

// File: rtl/pl_framer.sv
module pl_framer
  import pl_framer_pkg::*;
#(
  parameter int SYM_W      = 12,
  parameter int SLOT_LEN   = 90,
  parameter int PILOT_LEN  = 36,
  parameter int GRP_SLOTS  = 16,
  parameter int SLOT_CNT_W = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_valid_i,
  output logic                  start_ready_o,
  input  logic                  pilots_en_i,
  input  logic [SLOT_CNT_W-1:0] n_slots_i,
  input  logic [SYM_W-1:0]      hdr_re_i,
  input  logic [SYM_W-1:0]      hdr_im_i,
  input  logic                  hdr_valid_i,
  output logic                  hdr_ready_o,
  input  logic [SYM_W-1:0]      din_re_i,
  input  logic [SYM_W-1:0]      din_im_i,
  input  logic                  din_valid_i,
  output logic                  din_ready_o,
  output logic [SYM_W-1:0]      dout_re_o,
  output logic [SYM_W-1:0]      dout_im_o,
  output logic [1:0]            dout_type_o,
  output logic                  dout_last_o,
  output logic                  dout_valid_o,
  input  logic                  dout_ready_i
);

  localparam logic [SYM_W-1:0] PILOT_CHK = SYM_W'(pilot_amp(SYM_W));

  seg_e seg;
  logic last, beat;

  pl_frame_seq #(
    .SLOT_LEN  (SLOT_LEN),
    .PILOT_LEN (PILOT_LEN),
    .GRP_SLOTS (GRP_SLOTS),
    .SLOT_CNT_W(SLOT_CNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_valid_i(start_valid_i),
    .start_ready_o(start_ready_o),
    .pilots_en_i  (pilots_en_i),
    .n_slots_i    (n_slots_i),
    .beat_i       (beat),
    .seg_o        (seg),
    .last_o       (last)
  );

  pl_sym_mux #(
    .SYM_W(SYM_W)
  ) u_mux (
    .seg_i       (seg),
    .last_i      (last),
    .hdr_re_i    (hdr_re_i),
    .hdr_im_i    (hdr_im_i),
    .hdr_valid_i (hdr_valid_i),
    .hdr_ready_o (hdr_ready_o),
    .din_re_i    (din_re_i),
    .din_im_i    (din_im_i),
    .din_valid_i (din_valid_i),
    .din_ready_o (din_ready_o),
    .dout_re_o   (dout_re_o),
    .dout_im_o   (dout_im_o),
    .dout_type_o (dout_type_o),
    .dout_last_o (dout_last_o),
    .dout_valid_o(dout_valid_o),
    .dout_ready_i(dout_ready_i),
    .beat_o      (beat)
  );

  p_din_only_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_ready_o |-> (dout_type_o == TAG_DATA));

  p_pilot_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_valid_o && dout_type_o == TAG_PILOT) |->
      (dout_re_o == PILOT_CHK && dout_im_o == PILOT_CHK));

  p_last_on_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_last_o |-> (dout_type_o == TAG_DATA));

  p_no_take_stalled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_ready_i |-> (!hdr_ready_o && !din_ready_o));

  p_busy_blocks_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_valid_o && !(dout_last_o && dout_ready_i)) |=> !start_ready_o);

endmodule

// File: tb/pl_framer_bench.sv
`timescale 1ns/1ps
module pl_framer_bench;

  localparam int SYM_W      = 12;
  localparam int SLOT_LEN   = 90;
  localparam int PILOT_LEN  = 36;
  localparam int GRP_SLOTS  = 16;
  localparam int SLOT_CNT_W = 9;
  localparam int PERIOD_SYM = GRP_SLOTS * SLOT_LEN + PILOT_LEN;
  localparam int PILOT_EXP  = $rtoi(0.7071067811865476 * (2.0 ** (SYM_W - 1)) + 0.5);

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  start_valid_i = 1'b0;
  logic                  start_ready_o;
  logic                  pilots_en_i = 1'b0;
  logic [SLOT_CNT_W-1:0] n_slots_i = '0;
  logic [SYM_W-1:0]      hdr_re_i = '0;
  logic [SYM_W-1:0]      hdr_im_i = '0;
  logic                  hdr_valid_i = 1'b0;
  logic                  hdr_ready_o;
  logic [SYM_W-1:0]      din_re_i = '0;
  logic [SYM_W-1:0]      din_im_i = '0;
  logic                  din_valid_i = 1'b0;
  logic                  din_ready_o;
  logic [SYM_W-1:0]      dout_re_o;
  logic [SYM_W-1:0]      dout_im_o;
  logic [1:0]            dout_type_o;
  logic                  dout_last_o;
  logic                  dout_valid_o;
  logic                  dout_ready_i = 1'b0;

  int tests_run = 0;
  int tests_failed = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk_i = ~clk_i;

  pl_framer #(
    .SYM_W(SYM_W), .SLOT_LEN(SLOT_LEN), .PILOT_LEN(PILOT_LEN),
    .GRP_SLOTS(GRP_SLOTS), .SLOT_CNT_W(SLOT_CNT_W)
  ) u_pl_framer (
    .clk_i, .rst_ni, .start_valid_i, .start_ready_o, .pilots_en_i, .n_slots_i,
    .hdr_re_i, .hdr_im_i, .hdr_valid_i, .hdr_ready_o,
    .din_re_i, .din_im_i, .din_valid_i, .din_ready_o,
    .dout_re_o, .dout_im_o, .dout_type_o, .dout_last_o, .dout_valid_o, .dout_ready_i
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [SYM_W-1:0] hdr_re(input int h); return SYM_W'(h); endfunction
  function automatic logic [SYM_W-1:0] hdr_im(input int h); return SYM_W'(h) ^ 12'hA5A; endfunction
  function automatic logic [SYM_W-1:0] dat_re(input int d); return SYM_W'(d + 12'h300); endfunction
  function automatic logic [SYM_W-1:0] dat_im(input int d); return SYM_W'(d) ^ 12'h0F0; endfunction

  // expected beat from frame position
  task automatic expect_beat(input int idx, input int n, input bit pen,
                             output logic [1:0] t, output logic [SYM_W-1:0] re,
                             output logic [SYM_W-1:0] im, output bit last);
    int p, off, d;
    last = 1'b0;
    if (idx < SLOT_LEN) begin
      t = 2'b01; re = hdr_re(idx); im = hdr_im(idx);
    end else begin
      p = idx - SLOT_LEN;
      if (pen) begin
        off = p % PERIOD_SYM;
        if (off >= GRP_SLOTS * SLOT_LEN) begin
          t = 2'b11; re = SYM_W'(PILOT_EXP); im = SYM_W'(PILOT_EXP);
          return;
        end
        d = (p / PERIOD_SYM) * GRP_SLOTS * SLOT_LEN + off;
      end else begin
        d = p;
      end
      t = 2'b10; re = dat_re(d); im = dat_im(d);
      last = (d == n * SLOT_LEN - 1);
    end
  endtask

  task automatic run_frame(input int n, input bit pen, input bit stall, input bit hold_start);
    int total, out_idx, hdr_idx, dat_idx, mism, viol, npil, nlast, last_at, cyc;
    logic [1:0] et; logic [SYM_W-1:0] er, ei; bit el;
    total = SLOT_LEN + n * SLOT_LEN + (pen ? ((n - 1) / GRP_SLOTS) * PILOT_LEN : 0);
    out_idx = 0; hdr_idx = 0; dat_idx = 0; mism = 0; viol = 0;
    npil = 0; nlast = 0; last_at = -1; cyc = 0;
    @(negedge clk_i);
    start_valid_i = 1'b1; n_slots_i = SLOT_CNT_W'(n); pilots_en_i = pen;
    #1;
    chk(start_ready_o == 1'b1, "R10 start taken when idle", int'(start_ready_o), 1);
    @(negedge clk_i);
    // R9: disturb configuration after acceptance
    if (!hold_start) start_valid_i = 1'b0;
    n_slots_i = SLOT_CNT_W'(n + 5);
    pilots_en_i = !pen;
    while (out_idx < total && cyc < 20000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dout_ready_i = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      din_valid_i  = stall ? (lfsr[5] | lfsr[2]) : 1'b1;
      hdr_valid_i  = stall ? (lfsr[7] | lfsr[1]) : 1'b1;
      hdr_re_i = hdr_re(hdr_idx); hdr_im_i = hdr_im(hdr_idx);
      din_re_i = dat_re(dat_idx); din_im_i = dat_im(dat_idx);
      #1;
      if (!dout_ready_i && (hdr_ready_o || din_ready_o)) viol++;
      if (din_ready_o && dout_type_o != 2'b10) viol++;
      if (hdr_ready_o && dout_type_o != 2'b01) viol++;
      if (start_ready_o) viol++;
      if (dout_valid_o && dout_ready_i) begin
        expect_beat(out_idx, n, pen, et, er, ei, el);
        if (dout_type_o != et || dout_re_o != er || dout_im_o != ei ||
            dout_last_o != el) begin
          if (mism == 0)
            $display("  first mismatch beat %0d: type %0d/%0d re %0d/%0d im %0d/%0d last %0d/%0d",
                     out_idx, dout_type_o, et, dout_re_o, er, dout_im_o, ei, dout_last_o, el);
          mism++;
        end
        if (dout_type_o == 2'b11) npil++;
        if (dout_last_o) begin nlast++; last_at = out_idx; end
        out_idx++;
      end
      if (hdr_ready_o && hdr_valid_i) hdr_idx++;
      if (din_ready_o && din_valid_i) dat_idx++;
      @(negedge clk_i);
      cyc++;
    end
    start_valid_i = 1'b0;
    dout_ready_i = 1'b1;
    #1;
    chk(mism == 0, "R2 R11 R9 beat sequence", mism, 0);
    chk(out_idx == total, "R4 R5 frame length", out_idx, total);
    chk(npil == (pen ? ((n - 1) / GRP_SLOTS) * PILOT_LEN : 0), "R5 R6 pilot beats",
        npil, pen ? ((n - 1) / GRP_SLOTS) * PILOT_LEN : 0);
    chk(nlast == 1 && last_at == total - 1, "R7 last marker position", last_at, total - 1);
    chk(viol == 0, "R3 R8 R10 handshake rules", viol, 0);
    chk(dat_idx == n * SLOT_LEN, "R3 R11 data consumed", dat_idx, n * SLOT_LEN);
    chk(!dout_valid_o && start_ready_o, "R1 R10 idle after frame",
        int'({dout_valid_o, start_ready_o}), 1);
  endtask

  task automatic t_reset;
    #1;
    chk(!dout_valid_o && dout_type_o == 2'b00, "R1 output quiet in reset",
        int'({dout_valid_o, dout_type_o}), 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    dout_ready_i = 1'b1; hdr_valid_i = 1'b1; din_valid_i = 1'b1;
    #1;
    chk(start_ready_o && !hdr_ready_o && !din_ready_o && !dout_valid_o,
        "R1 idle state after reset",
        int'({start_ready_o, hdr_ready_o, din_ready_o, dout_valid_o}), 8);
  endtask

  task automatic t_short_no_pilot;   run_frame(3,  1'b0, 1'b0, 1'b0); endtask // R4 R2
  task automatic t_long_no_pilot;    run_frame(20, 1'b0, 1'b0, 1'b0); endtask // R4
  task automatic t_one_pilot;        run_frame(17, 1'b1, 1'b0, 1'b0); endtask // R5
  task automatic t_drop_single;      run_frame(16, 1'b1, 1'b0, 1'b0); endtask // R6
  task automatic t_drop_final;       run_frame(32, 1'b1, 1'b0, 1'b0); endtask // R6
  task automatic t_stalls;           run_frame(33, 1'b1, 1'b1, 1'b0); endtask // R8
  task automatic t_start_held;       run_frame(18, 1'b1, 1'b0, 1'b1); endtask // R9 R10

  initial begin
    #2_000_000;
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    t_reset();
    t_short_no_pilot();
    t_long_no_pilot();
    t_one_pilot();
    t_drop_single();
    t_drop_final();
    t_stalls();
    t_start_held();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule